// File: doc/BRIEF.md
# Bus Slave Address Decoder for a 1 KB I/O Block

This block sits at the slave side of a 24-bit-address, 16-bit-data backplane bus and decides, on every clock, whether the cycle currently on the bus belongs to this module. A cycle is claimed only when three things hold. The address-modifier code must be one that the configured address space and privilege setting allow. The address must fall inside the module's 1 KB window. The address strobe and at least one data strobe must be active. The window sits at one of 64 bases at 1 KB spacing, picked by a 6-bit base setting. In the short 64 KB space the upper address byte is not looked at. In the standard space the window is confined to the topmost 64 KB segment.

When a cycle is claimed, the low address bits and the two byte-lane strobes are decoded into one strobe per register. The registers are identification characters, an extended status byte, a status/control byte, an interrupt vector byte, one data byte per input port and one change byte per input port. Each register is given the direction it supports, so a strobe is asserted only for an access in that direction. Any other access inside the window still raises the module select, so that the cycle is acknowledged, but it raises no register strobe. All outputs are registered and follow the bus inputs by one clock.

Top module: `bus_slave_decode`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is sampled high, every output is 0.
- R2: With `std_space` = 0, modifier 2Dh is accepted. Modifier 29h is accepted only when `sup_only` = 0. Every other code yields `mod_sel` = 0.
- R3: With `std_space` = 1, modifier 3Dh is accepted. Modifier 39h is accepted only when `sup_only` = 0. Every other code, including the short-space codes, yields `mod_sel` = 0.
- R4: The window matches when `addr_hi[5:0]` (A15-A10) equals `base_sel`. In short space `addr_hi[13:6]` (A23-A16) has no effect on the result.
- R5: In standard space the window additionally requires A23-A16 to all be 1.
- R6: No select is produced unless `addr_strobe` = 1 and `ds` != 0. Here `ds[1]` enables the even byte (A0 = 0) and `ds[0]` enables the odd byte (A0 = 1).
- R7: A read with `ds[0]` set at word offsets 00h-3Eh (odd byte offsets 01h-3Fh) asserts `id_rd`, with `id_idx` = byte offset >> 1. An even-lane access or a write in that range gives only `mod_sel`. When `id_rd` = 0, `id_idx` is 0.
- R8: Byte 80h, read on the even lane, asserts `xstat_rd`. Byte 81h on the odd lane asserts `ctrl_rd` on a read and `ctrl_wr` on a write. Byte 83h on the odd lane asserts `vec_wr` on a write only.
- R9: Port p's data byte is read at A0h + p and its change byte at B0h + p. Even p uses the even lane and odd p uses the odd lane, so a word read at A0h/A2h (or B0h/B2h) covers two ports at once. Writes there give only `mod_sel`.
- R10: Any claimed access that matches no register (for example offset 100h) asserts `mod_sel` with every register strobe 0.
- R11: Every output reflects the bus inputs sampled at the previous rising edge, with no hold-over between back-to-back cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_hi | input | 14 | Address bits A23-A10 |
| addr_lo | input | 9 | Address bits A9-A1 (word within the block) |
| am | input | 6 | Address-modifier code |
| addr_strobe | input | 1 | Address strobe, active high |
| ds | input | 2 | Byte-lane strobes: bit 1 even byte, bit 0 odd byte |
| wr | input | 1 | 1 = write cycle, 0 = read cycle |
| base_sel | input | 6 | 1 KB block number within the 64 KB segment |
| sup_only | input | 1 | 1 = accept supervisory codes only |
| std_space | input | 1 | 0 = short 64 KB space, 1 = standard space, top segment |
| mod_sel | output | 1 | Cycle claimed by this module |
| id_rd | output | 1 | Identification character read |
| id_idx | output | 5 | Identification character index |
| xstat_rd | output | 1 | Extended status read |
| ctrl_rd | output | 1 | Status/control read |
| ctrl_wr | output | 1 | Status/control write |
| vec_wr | output | 1 | Interrupt vector write |
| data_rd | output | 4 | Per-port data byte read |
| chg_rd | output | 4 | Per-port change byte read |

## Verification
A wrong modifier or segment term would claim a cycle that belongs to another module, or drop one that belongs to this one. That error shows on `mod_sel` exactly one clock after the offending bus inputs. A fault in the offset or lane decode shows in that same cycle as a strobe on the wrong register or lane, as two strobes at once, or as a strobe in the wrong direction. A stale register stage shows when an access is followed at once by a different one. The stimulus therefore runs accesses back to back, and every access is compared in the cycle after it is driven.

// File: rtl/bsd_pkg.sv
package bsd_pkg;

    typedef enum logic {
        SPACE_SHORT = 1'b0,
        SPACE_STD   = 1'b1
    } space_e;

    localparam logic [5:0] AM_SHORT_USER = 6'h29;
    localparam logic [5:0] AM_SHORT_SUP  = 6'h2D;
    localparam logic [5:0] AM_STD_USER   = 6'h39;
    localparam logic [5:0] AM_STD_SUP    = 6'h3D;

    // byte offsets inside the 1 KB block
    localparam int OFS_XSTAT = 'h80;
    localparam int OFS_CTRL  = 'h81;
    localparam int OFS_VEC   = 'h83;
    localparam int OFS_DATA  = 'hA0;
    localparam int OFS_CHG   = 'hB0;

    // lane index within ds
    localparam int LANE_ODD  = 0;
    localparam int LANE_EVEN = 1;

    typedef struct packed {
        logic id;
        logic xstat;
        logic ctrl_rd;
        logic ctrl_wr;
        logic vec;
    } ctl_sel_t;

    function automatic logic am_accept(input logic [5:0] code,
                                       input space_e sp,
                                       input logic sup_only);
        logic sup_hit, usr_hit;
        if (sp == SPACE_STD) begin
            sup_hit = (code == AM_STD_SUP);
            usr_hit = (code == AM_STD_USER);
        end else begin
            sup_hit = (code == AM_SHORT_SUP);
            usr_hit = (code == AM_SHORT_USER);
        end
        return sup_hit || (usr_hit && !sup_only);
    endfunction

endpackage

// File: rtl/bsd_am_qual.sv
module bsd_am_qual
    import bsd_pkg::*;
(
    input  logic [5:0] am,
    input  space_e     sp,
    input  logic       sup_only,
    output logic       am_hit
);
    assign am_hit = am_accept(am, sp, sup_only);
endmodule

// File: rtl/bsd_addr_match.sv
module bsd_addr_match
    import bsd_pkg::*;
#(
    parameter int HI_W   = 14,
    parameter int BASE_W = 6
) (
    input  logic [HI_W-1:0]   hi,
    input  logic [BASE_W-1:0] base,
    input  space_e            sp,
    output logic              addr_hit
);
    localparam int SEGBITS_W = HI_W - BASE_W;

    logic [SEGBITS_W-1:0] seg_bits;
    logic                 seg_top;
    logic                 blk_eq;

    assign seg_bits = hi[HI_W-1:BASE_W];
    assign seg_top  = &seg_bits;
    assign blk_eq   = (hi[BASE_W-1:0] == base);
    assign addr_hit = blk_eq && ((sp == SPACE_SHORT) || seg_top);
endmodule

// File: rtl/bsd_reg_dec.sv
module bsd_reg_dec
    import bsd_pkg::*;
#(
    parameter int WORD_W   = 9,
    parameter int PORTS    = 4,
    parameter int ID_CHARS = 32,
    parameter int IDX_W    = 5
) (
    input  logic [WORD_W-1:0] word,
    input  logic [1:0]        lanes,
    input  logic              wr,
    output ctl_sel_t          ctl,
    output logic [IDX_W-1:0]  idx,
    output logic [PORTS-1:0]  data,
    output logic [PORTS-1:0]  chg
);
    localparam int BYTE_W = WORD_W + 1;
    localparam logic [BYTE_W-1:0] XSTAT_B = BYTE_W'(OFS_XSTAT);
    localparam logic [BYTE_W-1:0] CTRL_B  = BYTE_W'(OFS_CTRL);
    localparam logic [BYTE_W-1:0] VEC_B   = BYTE_W'(OFS_VEC);
    localparam logic [WORD_W-1:0] ID_END  = WORD_W'(ID_CHARS);

    logic odd_l, even_l, in_id;

    assign odd_l  = lanes[LANE_ODD];
    assign even_l = lanes[LANE_EVEN];
    assign in_id  = (word < ID_END);

    always_comb begin
        ctl.id      = !wr && odd_l && in_id;
        ctl.xstat   = !wr && even_l && (word == XSTAT_B[BYTE_W-1:1]);
        ctl.ctrl_rd = !wr && odd_l  && (word == CTRL_B[BYTE_W-1:1]);
        ctl.ctrl_wr =  wr && odd_l  && (word == CTRL_B[BYTE_W-1:1]);
        ctl.vec     =  wr && odd_l  && (word == VEC_B[BYTE_W-1:1]);
        idx         = ctl.id ? word[IDX_W-1:0] : '0;
    end

    for (genvar p = 0; p < PORTS; p++) begin : g_port
        localparam logic [BYTE_W-1:0] D_B = BYTE_W'(OFS_DATA + p);
        localparam logic [BYTE_W-1:0] C_B = BYTE_W'(OFS_CHG + p);
        localparam int LB = D_B[0] ? LANE_ODD : LANE_EVEN;
        assign data[p] = !wr && lanes[LB] && (word == D_B[BYTE_W-1:1]);
        assign chg[p]  = !wr && lanes[LB] && (word == C_B[BYTE_W-1:1]);
    end
endmodule

// File: rtl/bus_slave_decode.sv
module bus_slave_decode
    import bsd_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int SEG_W    = 16,
    parameter int BLK_W    = 10,
    parameter int PORTS    = 4,
    parameter int ID_CHARS = 32,
    localparam int HI_W    = ADDR_W - BLK_W,
    localparam int LO_W    = BLK_W - 1,
    localparam int BASE_W  = SEG_W - BLK_W,
    localparam int IDX_W   = $clog2(ID_CHARS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [HI_W-1:0]   addr_hi,
    input  logic [LO_W-1:0]   addr_lo,
    input  logic [5:0]        am,
    input  logic              addr_strobe,
    input  logic [1:0]        ds,
    input  logic              wr,
    input  logic [BASE_W-1:0] base_sel,
    input  logic              sup_only,
    input  logic              std_space,
    output logic              mod_sel,
    output logic              id_rd,
    output logic [IDX_W-1:0]  id_idx,
    output logic              xstat_rd,
    output logic              ctrl_rd,
    output logic              ctrl_wr,
    output logic              vec_wr,
    output logic [PORTS-1:0]  data_rd,
    output logic [PORTS-1:0]  chg_rd
);
    space_e           sp;
    logic             am_hit, addr_hit, claim;
    ctl_sel_t         ctl_d, ctl_q;
    logic [IDX_W-1:0] idx_d, idx_q;
    logic [PORTS-1:0] data_d, chg_d, data_q, chg_q;
    logic             sel_q;

    assign sp = space_e'(std_space);

    bsd_am_qual u_am (
        .am       (am),
        .sp       (sp),
        .sup_only (sup_only),
        .am_hit   (am_hit)
    );

    bsd_addr_match #(.HI_W(HI_W), .BASE_W(BASE_W)) u_match (
        .hi       (addr_hi),
        .base     (base_sel),
        .sp       (sp),
        .addr_hit (addr_hit)
    );

    bsd_reg_dec #(
        .WORD_W(LO_W), .PORTS(PORTS), .ID_CHARS(ID_CHARS), .IDX_W(IDX_W)
    ) u_dec (
        .word  (addr_lo),
        .lanes (ds),
        .wr    (wr),
        .ctl   (ctl_d),
        .idx   (idx_d),
        .data  (data_d),
        .chg   (chg_d)
    );

    assign claim = addr_strobe && (ds != 2'b00) && am_hit && addr_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= 1'b0;
            ctl_q  <= '0;
            idx_q  <= '0;
            data_q <= '0;
            chg_q  <= '0;
        end else begin
            sel_q  <= claim;
            ctl_q  <= claim ? ctl_d  : '0;
            idx_q  <= claim ? idx_d  : '0;
            data_q <= claim ? data_d : '0;
            chg_q  <= claim ? chg_d  : '0;
        end
    end

    assign mod_sel  = sel_q;
    assign id_rd    = ctl_q.id;
    assign id_idx   = idx_q;
    assign xstat_rd = ctl_q.xstat;
    assign ctrl_rd  = ctl_q.ctrl_rd;
    assign ctrl_wr  = ctl_q.ctrl_wr;
    assign vec_wr   = ctl_q.vec;
    assign data_rd  = data_q;
    assign chg_rd   = chg_q;
endmodule

// File: rtl/bus_slave_decode_chk.sv
module bus_slave_decode_chk #(
    parameter int HI_W   = 14,
    parameter int LO_W   = 9,
    parameter int BASE_W = 6,
    parameter int IDX_W  = 5,
    parameter int PORTS  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [HI_W-1:0]   addr_hi,
    input logic [LO_W-1:0]   addr_lo,
    input logic [5:0]        am,
    input logic              addr_strobe,
    input logic [1:0]        ds,
    input logic              wr,
    input logic [BASE_W-1:0] base_sel,
    input logic              sup_only,
    input logic              std_space,
    input logic              mod_sel,
    input logic              id_rd,
    input logic [IDX_W-1:0]  id_idx,
    input logic              xstat_rd,
    input logic              ctrl_rd,
    input logic              ctrl_wr,
    input logic              vec_wr,
    input logic [PORTS-1:0]  data_rd,
    input logic [PORTS-1:0]  chg_rd
);
    logic seg_all, any_reg, strobe_ok;
    assign seg_all   = &addr_hi[HI_W-1:BASE_W];
    assign strobe_ok = addr_strobe && (ds != 2'b00);
    assign any_reg   = id_rd || xstat_rd || ctrl_rd || ctrl_wr || vec_wr
                       || (|data_rd) || (|chg_rd);

    assert_strobe_needed_R6: assert property (@(posedge clk) disable iff (rst)
        mod_sel |-> $past(strobe_ok));

    assert_reg_in_block_R10: assert property (@(posedge clk) disable iff (rst)
        any_reg |-> mod_sel);

    assert_vec_write_only_R8: assert property (@(posedge clk) disable iff (rst)
        vec_wr |-> $past(wr));

    assert_ports_read_only_R9: assert property (@(posedge clk) disable iff (rst)
        ((|data_rd) || (|chg_rd)) |-> !$past(wr));

    assert_one_register_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({id_rd, vec_wr, |data_rd, |chg_rd, xstat_rd | ctrl_rd | ctrl_wr}));

    assert_top_segment_R5: assert property (@(posedge clk) disable iff (rst)
        (mod_sel && $past(std_space)) |-> $past(seg_all));

    assert_sup_short_R2: assert property (@(posedge clk) disable iff (rst)
        (mod_sel && $past(sup_only) && !$past(std_space)) |-> ($past(am) == 6'h2D));

    assert_id_index_zero_R7: assert property (@(posedge clk) disable iff (rst)
        !id_rd |-> (id_idx == '0));
endmodule

bind bus_slave_decode bus_slave_decode_chk #(
    .HI_W(HI_W), .LO_W(LO_W), .BASE_W(BASE_W), .IDX_W(IDX_W), .PORTS(PORTS)
) chk_i (.*);

// File: tb/bus_slave_decode_tb.sv
`timescale 1ns/1ps
module bus_slave_decode_tb_top;

    typedef struct {
        logic [18:0] v;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [13:0] addr_hi = '0;
    logic [8:0]  addr_lo = '0;
    logic [5:0]  am = '0;
    logic        addr_strobe = 1'b0;
    logic [1:0]  ds = '0;
    logic        wr = 1'b0;
    logic [5:0]  base_sel = '0;
    logic        sup_only = 1'b0;
    logic        std_space = 1'b0;
    logic        mod_sel, id_rd, xstat_rd, ctrl_rd, ctrl_wr, vec_wr;
    logic [4:0]  id_idx;
    logic [3:0]  data_rd, chg_rd;

    int    n_run = 0;
    int    n_fail = 0;
    bit    done = 0;
    item_t q[$];

    logic [5:0] cfg_base = 6'h01;
    logic       cfg_sup = 1'b0;
    logic       cfg_std = 1'b0;
    logic       cfg_strobe = 1'b1;

    always #2 clk = ~clk;

    bus_slave_decode dut_i (
        .clk(clk), .rst(rst), .addr_hi(addr_hi), .addr_lo(addr_lo), .am(am),
        .addr_strobe(addr_strobe), .ds(ds), .wr(wr), .base_sel(base_sel),
        .sup_only(sup_only), .std_space(std_space), .mod_sel(mod_sel),
        .id_rd(id_rd), .id_idx(id_idx), .xstat_rd(xstat_rd), .ctrl_rd(ctrl_rd),
        .ctrl_wr(ctrl_wr), .vec_wr(vec_wr), .data_rd(data_rd), .chg_rd(chg_rd)
    );

    function automatic logic [18:0] actual();
        return {mod_sel, id_rd, id_idx, xstat_rd, ctrl_rd, ctrl_wr, vec_wr,
                data_rd, chg_rd};
    endfunction

    // expected outputs, derived from the requirements
    function automatic logic [18:0] model(logic [23:0] a, logic [5:0] code,
                                          logic stb, logic [1:0] lane, logic w,
                                          logic [5:0] base, logic sup, logic std);
        logic amok, adok;
        logic [9:0] off;
        logic idr, xs, cr, cw, vw;
        logic [4:0] idx;
        logic [3:0] dr, cg;
        off  = {a[9:1], 1'b0};
        amok = std ? (code == 6'h3D || (!sup && code == 6'h39))
                   : (code == 6'h2D || (!sup && code == 6'h29));
        adok = (a[15:10] == base) && (!std || a[23:16] == 8'hFF);
        if (!(stb && lane != 2'b00 && amok && adok)) return '0;
        idr = !w && lane[0] && off < 10'h40;
        idx = idr ? a[5:1] : 5'd0;
        xs  = !w && lane[1] && off == 10'h80;
        cr  = !w && lane[0] && off == 10'h80;
        cw  =  w && lane[0] && off == 10'h80;
        vw  =  w && lane[0] && off == 10'h82;
        for (int p = 0; p < 4; p++) begin
            dr[p] = !w && (off == 10'hA0 + 10'((p / 2) * 2)) && lane[(p % 2) ? 0 : 1];
            cg[p] = !w && (off == 10'hB0 + 10'((p / 2) * 2)) && lane[(p % 2) ? 0 : 1];
        end
        return {1'b1, idr, idx, xs, cr, cw, vw, dr, cg};
    endfunction

    task automatic acc(input logic [23:0] a, input logic [5:0] code,
                       input logic [1:0] lane, input logic w, input string tag);
        item_t it;
        @(negedge clk);
        addr_hi     = a[23:10];
        addr_lo     = a[9:1];
        am          = code;
        ds          = lane;
        wr          = w;
        addr_strobe = cfg_strobe;
        base_sel    = cfg_base;
        sup_only    = cfg_sup;
        std_space   = cfg_std;
        it.v   = model(a, code, cfg_strobe, lane, w, cfg_base, cfg_sup, cfg_std);
        it.tag = tag;
        q.push_back(it);
    endtask

    // monitor: one item per edge, compared after the registers settle
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                n_run++;
                if (actual() !== it.v) begin
                    n_fail++;
                    $display("FAIL %s: actual %05h expected %05h", it.tag, actual(), it.v);
                end
            end
        end
    end

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL R11: watchdog expired, actual hung expected done");
            finish_run();
        end
    end

    initial begin
        // R1: a valid access during reset yields nothing
        @(negedge clk);
        addr_hi = 14'h0001; addr_lo = 9'h040; am = 6'h2D; ds = 2'b01;
        addr_strobe = 1'b1; base_sel = 6'h01;
        repeat (2) @(posedge clk);
        #1;
        n_run++;
        if (actual() !== '0) begin
            n_fail++;
            $display("FAIL R1: actual %05h expected 00000", actual());
        end
        @(negedge clk);
        rst = 1'b0;
        addr_strobe = 1'b0;

        // R2: short space modifiers, example base 0400h -> 0481h
        acc(24'h000481, 6'h29, 2'b01, 1'b0, "R2");
        acc(24'h000481, 6'h2D, 2'b01, 1'b0, "R2");
        acc(24'h000481, 6'h39, 2'b01, 1'b0, "R2");
        acc(24'h000481, 6'h09, 2'b01, 1'b0, "R2");
        cfg_sup = 1'b1;
        acc(24'h000481, 6'h29, 2'b01, 1'b0, "R2");
        acc(24'h000481, 6'h2D, 2'b01, 1'b0, "R2");

        // R3/R5: standard space, top segment only
        cfg_std = 1'b1; cfg_sup = 1'b0;
        acc(24'hFF0481, 6'h39, 2'b01, 1'b0, "R3");
        acc(24'hFF0481, 6'h3D, 2'b01, 1'b0, "R3");
        acc(24'hFF0481, 6'h2D, 2'b01, 1'b0, "R3");
        cfg_sup = 1'b1;
        acc(24'hFF0481, 6'h39, 2'b01, 1'b0, "R3");
        acc(24'hFF0481, 6'h3D, 2'b01, 1'b0, "R3");
        acc(24'hFE0481, 6'h3D, 2'b01, 1'b0, "R5");
        acc(24'h7F0481, 6'h3D, 2'b01, 1'b0, "R5");

        // R4: block match, upper byte ignored in short space
        cfg_std = 1'b0; cfg_sup = 1'b0;
        acc(24'h5A0481, 6'h2D, 2'b01, 1'b0, "R4");
        acc(24'h000881, 6'h2D, 2'b01, 1'b0, "R4");
        cfg_base = 6'h3F;
        acc(24'h00FC81, 6'h2D, 2'b01, 1'b0, "R4");
        acc(24'h000481, 6'h2D, 2'b01, 1'b0, "R4");
        cfg_base = 6'h01;

        // R6: strobes required
        cfg_strobe = 1'b0;
        acc(24'h000481, 6'h2D, 2'b01, 1'b0, "R6");
        cfg_strobe = 1'b1;
        acc(24'h000481, 6'h2D, 2'b00, 1'b0, "R6");

        // R7: identification characters
        acc(24'h000401, 6'h2D, 2'b01, 1'b0, "R7");
        acc(24'h00043F, 6'h2D, 2'b01, 1'b0, "R7");
        acc(24'h000414, 6'h2D, 2'b11, 1'b0, "R7");
        acc(24'h000420, 6'h2D, 2'b10, 1'b0, "R7");
        acc(24'h000405, 6'h2D, 2'b01, 1'b1, "R7");

        // R8: status, control, vector
        acc(24'h000480, 6'h2D, 2'b10, 1'b0, "R8");
        acc(24'h000480, 6'h2D, 2'b11, 1'b0, "R8");
        acc(24'h000481, 6'h2D, 2'b01, 1'b1, "R8");
        acc(24'h000480, 6'h2D, 2'b10, 1'b1, "R8");
        acc(24'h000483, 6'h2D, 2'b01, 1'b1, "R8");
        acc(24'h000483, 6'h2D, 2'b01, 1'b0, "R8");

        // R9: data and change byte pairs
        acc(24'h0004A0, 6'h2D, 2'b11, 1'b0, "R9");
        acc(24'h0004A3, 6'h2D, 2'b01, 1'b0, "R9");
        acc(24'h0004A2, 6'h2D, 2'b10, 1'b0, "R9");
        acc(24'h0004B2, 6'h2D, 2'b11, 1'b0, "R9");
        acc(24'h0004B0, 6'h2D, 2'b10, 1'b0, "R9");
        acc(24'h0004A0, 6'h2D, 2'b11, 1'b1, "R9");

        // R10: undefined offsets
        acc(24'h000500, 6'h2D, 2'b11, 1'b0, "R10");
        acc(24'h0007FE, 6'h2D, 2'b11, 1'b1, "R10");
        acc(24'h000484, 6'h2D, 2'b01, 1'b0, "R10");

        // R11: back-to-back switching, no hold-over
        acc(24'h0004B1, 6'h2D, 2'b01, 1'b0, "R11");
        acc(24'h000403, 6'h2D, 2'b01, 1'b0, "R11");
        acc(24'h000881, 6'h2D, 2'b01, 1'b0, "R11");
        acc(24'h000483, 6'h2D, 2'b01, 1'b1, "R11");

        @(negedge clk);
        addr_strobe = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        done = 1;
        finish_run();
    end
endmodule